// File: doc/BRIEF.md
# Registered Bus Transceiver

This block passes 18-bit data between two ports, A and B, in both directions at once. Each direction owns one storage element that can be transparent, can hold its contents, or can act as a flip-flop that loads on the falling edge of that direction's own strobe clock. Each direction has a load-enable, a strobe clock and a drive-enable input. The A-to-B drive-enable is active-high and the B-to-A drive-enable is active-low.

The strobe clocks are ordinary data inputs, sampled by a fast system clock `clk`. A falling edge is found by comparing a strobe with its registered copy. While a direction's load-enable is high, its output follows the opposite port's input with no delay, and the storage element reloads on every system clock. Each output is presented as a data word plus a drive flag, so a pad wrapper can turn the pair into a tri-state pin. A synchronous active-low reset clears both storage elements and turns off both drivers.

Top module: `regbus_xcvr`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle, and the value is also stored at each rising edge of `clk`.
- R2: While `ab_le` is 0, a falling edge on `ab_tick` (1 at the previous `clk` sample, 0 now) loads `a_in` into the A-to-B store, and `b_out` shows it after that `clk` edge.
- R3: While `ab_le` is 0 and `ab_tick` stays at a steady level (high or low), `b_out` keeps its stored value whatever `a_in` does.
- R4: If `ab_tick` is already low when `ab_le` falls, the value loaded while `ab_le` was high is kept. If `ab_tick` is high when `ab_le` falls, the next falling edge of `ab_tick` loads new data.
- R5: `b_drv` is 1 exactly when `ab_en` is 1 (active-high) and the block is out of reset.
- R6: `a_drv` is 1 exactly when `ba_en_n` is 0 (active-low) and the block is out of reset.
- R7: The B-to-A path (`b_in`, `ba_le`, `ba_tick`, `a_out`) has the transparent, edge-load and hold behaviour of R1 to R3, and it does not depend on any A-to-B input.
- R8: When `rst_n` is 0 at a `clk` edge, both stores clear to zero and both drive flags are 0 after that edge.
- R9: Toggling `ab_tick` while `ab_le` is 1 does not disturb the transparent data: `b_out` still equals `a_in`.
- R10: A rising edge on `ab_tick` while `ab_le` is 0 loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | W | Data arriving on port A |
| b_in | input | W | Data arriving on port B |
| ab_le | input | 1 | A-to-B load-enable (1 = transparent) |
| ab_tick | input | 1 | A-to-B strobe clock; loads on its falling edge |
| ab_en | input | 1 | A-to-B drive-enable, active-high |
| ba_le | input | 1 | B-to-A load-enable (1 = transparent) |
| ba_tick | input | 1 | B-to-A strobe clock; loads on its falling edge |
| ba_en_n | input | 1 | B-to-A drive-enable, active-low |
| b_out | output | W | Data presented on port B |
| b_drv | output | 1 | Port B driver on |
| a_out | output | W | Data presented on port A |
| a_drv | output | 1 | Port A driver on |

## Verification
The bench builds the block with the default width W = 18, so every data pattern covers the full word, including its top bit. At that width, values with alternating bits show whether the two directions ever mix their data. A strobe is held high or low for several system cycles, which makes the steady-level hold and the edge detection visible as separate cycles.

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_le,
  input  logic         ab_tick,
  input  logic         ab_en,
  input  logic         ba_le,
  input  logic         ba_tick,
  input  logic         ba_en_n,
  output logic [W-1:0] b_out,
  output logic         b_drv,
  output logic [W-1:0] a_out,
  output logic         a_drv
);

  logic [W-1:0] st_ab, st_ba;
  logic         ab_tick_q, ba_tick_q, run;
  logic         ab_fall, ba_fall;

  assign ab_fall = ab_tick_q & ~ab_tick;
  assign ba_fall = ba_tick_q & ~ba_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_ab     <= '0;
      ab_tick_q <= 1'b0;
    end else begin
      ab_tick_q <= ab_tick;
      if (ab_le || ab_fall) st_ab <= a_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_ba     <= '0;
      ba_tick_q <= 1'b0;
    end else begin
      ba_tick_q <= ba_tick;
      if (ba_le || ba_fall) st_ba <= b_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) run <= 1'b0;
    else        run <= 1'b1;
  end

  assign b_out = ab_le ? a_in : st_ab;
  assign a_out = ba_le ? b_in : st_ba;
  assign b_drv = run & ab_en;
  assign a_drv = run & ~ba_en_n;

  // transparent cycle leaves the input in the store
  assert_transparent_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && ab_le) |=> (b_out == $past(a_in) || ab_le));

  // falling strobe with load-enable low loads the input
  assert_fall_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !ab_le && $fell(ab_tick)) |=> (st_ab == $past(a_in)));

  // steady strobe with load-enable low keeps the store
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !ab_le && $stable(ab_tick)) |=> $stable(st_ab));

  // mirror path loads on its own falling strobe
  assert_ba_fall_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !ba_le && $fell(ba_tick)) |=> (st_ba == $past(b_in)));

  // reset turns both drivers off
  assert_reset_drv_off_R8: assert property (@(posedge clk)
    !rst_n |=> (!a_drv && !b_drv));

endmodule

// File: tb/test_regbus_xcvr.sv
module test_regbus_xcvr;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in;
  logic         ab_le, ab_tick, ab_en, ba_le, ba_tick, ba_en_n;
  logic [W-1:0] b_out, a_out;
  logic         b_drv, a_drv;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [W-1:0] b;
    logic         bd;
    logic [W-1:0] a;
    logic         ad;
    string        tag;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  regbus_xcvr #(.W(W)) i_regbus_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_le(ab_le), .ab_tick(ab_tick), .ab_en(ab_en),
    .ba_le(ba_le), .ba_tick(ba_tick), .ba_en_n(ba_en_n),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
  );

  task automatic cmp(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      cmp(e.tag, "b_out", b_out, e.b);
      cmp(e.tag, "b_drv", {{(W-1){1'b0}}, b_drv}, {{(W-1){1'b0}}, e.bd});
      cmp(e.tag, "a_out", a_out, e.a);
      cmp(e.tag, "a_drv", {{(W-1){1'b0}}, a_drv}, {{(W-1){1'b0}}, e.ad});
    end
  end

  task automatic cyc(input logic [W-1:0] eb, input logic ebd, input logic [W-1:0] ea, input logic ead, input string tag);
    exp_t e;
    e.b = eb; e.bd = ebd; e.a = ea; e.ad = ead; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; a_in = 18'h15555; b_in = 18'h2AAAA;
    ab_le = 1'b0; ab_tick = 1'b0; ab_en = 1'b1;
    ba_le = 1'b0; ba_tick = 1'b0; ba_en_n = 1'b0;
    @(negedge clk);
    cyc('0, 1'b0, '0, 1'b0, "R8 reset state");

    rst_n = 1'b1; ab_le = 1'b1; a_in = 18'h3C0F1; b_in = 18'h01234;
    cyc(18'h3C0F1, 1'b1, '0, 1'b1, "R1 R5 R6 transparent");
    ab_tick = 1'b1; a_in = 18'h20001; b_in = 18'h3FFFF;
    cyc(18'h20001, 1'b1, '0, 1'b1, "R9 strobe high while transparent");
    ab_tick = 1'b0; a_in = 18'h1E1E1;
    cyc(18'h1E1E1, 1'b1, '0, 1'b1, "R9 strobe low while transparent");
    ab_le = 1'b0; a_in = 18'h00FF0;
    cyc(18'h1E1E1, 1'b1, '0, 1'b1, "R4 strobe low when le falls");
    a_in = 18'h33333;
    cyc(18'h1E1E1, 1'b1, '0, 1'b1, "R3 hold low");
    ab_tick = 1'b1; a_in = 18'h0ABCD;
    cyc(18'h1E1E1, 1'b1, '0, 1'b1, "R10 rising edge ignored");
    a_in = 18'h12345;
    cyc(18'h1E1E1, 1'b1, '0, 1'b1, "R3 hold high");
    ab_tick = 1'b0; a_in = 18'h2D2D2;
    cyc(18'h2D2D2, 1'b1, '0, 1'b1, "R2 falling edge load");
    a_in = 18'h00001;
    cyc(18'h2D2D2, 1'b1, '0, 1'b1, "R3 hold after load");
    ab_en = 1'b0;
    cyc(18'h2D2D2, 1'b0, '0, 1'b1, "R5 driver off");
    ab_le = 1'b1; ab_tick = 1'b1; a_in = 18'h3A5A5;
    cyc(18'h3A5A5, 1'b0, '0, 1'b1, "R4 transparent with strobe high");
    ab_le = 1'b0; a_in = 18'h05A5A;
    cyc(18'h3A5A5, 1'b0, '0, 1'b1, "R4 le falls with strobe high");
    ab_tick = 1'b0; a_in = 18'h13579;
    cyc(18'h13579, 1'b0, '0, 1'b1, "R4 later falling edge loads");

    ba_le = 1'b1; b_in = 18'h2468A; a_in = 18'h3FFFF;
    cyc(18'h13579, 1'b0, 18'h2468A, 1'b1, "R7 transparent B to A");
    ba_le = 1'b0; ba_tick = 1'b1; b_in = 18'h11111;
    cyc(18'h13579, 1'b0, 18'h2468A, 1'b1, "R7 rising edge ignored");
    ba_tick = 1'b0; b_in = 18'h0F0F0;
    cyc(18'h13579, 1'b0, 18'h0F0F0, 1'b1, "R7 falling edge load");
    b_in = 18'h22222;
    cyc(18'h13579, 1'b0, 18'h0F0F0, 1'b1, "R7 hold");
    ba_en_n = 1'b1;
    cyc(18'h13579, 1'b0, 18'h0F0F0, 1'b0, "R6 driver off");

    rst_n = 1'b0; ab_en = 1'b1; ba_en_n = 1'b0;
    cyc('0, 1'b0, '0, 1'b0, "R8 reset clears stores");
    rst_n = 1'b1;
    cyc('0, 1'b1, '0, 1'b1, "R8 stores stay clear after reset");

    while (sb.size() > 0) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule